// File: doc/BRIEF.md
# Edge Filter Mode Classifier

This block sits in front of a deblocking filter datapath and decides, for one edge segment, whether the filter should leave the edge alone (SKIP), apply the gentle clipped filter (WEAK) or apply the heavy smoothing filter (STRONG). It also produces the clipping bound that the weak filter uses. Each decision takes eight pixels across the edge, four on each side, plus the quantizer value and two edge thresholds.

A single select input switches the block between two rule sets. In the in-loop rule set a boundary strength code, computed elsewhere, picks the filter strength, and three pixel-gradient checks can veto filtering. In the post-loop rule set the boundary strength code is ignored. The block counts flat neighbour pairs across the edge, and a quantizer-dependent step threshold lets sharp real edges be skipped. Both rule sets share one comparator for the step across the edge. The decision is registered, so a result appears one cycle after its input, with a valid flag.

Top module: `deblock_mode_decide`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A decision for inputs presented with `in_valid` high appears on `mode`/`tc` after the next rising edge.
- R2: Mode encoding is 0 = SKIP, 1 = WEAK, 2 = STRONG. The value 3 never appears.
- R3: In in-loop mode (`post_mode`=0), a boundary strength of 0 gives SKIP.
- R4: In in-loop mode, the result is SKIP unless all three strict checks hold: |p0-q0| < alpha, |p1-p0| < beta and |q1-q0| < beta. Pixel i sits in `pix[8i+7:8i]`, in the order p3, p2, p1, p0, q0, q1, q2, q3 for i = 0..7.
- R5: In in-loop mode with all checks passing, a strength of 4 to 7 gives STRONG and a strength of 1 to 3 gives WEAK.
- R6: In post-loop mode (`post_mode`=1), the result is SKIP when |p0-q0| >= alpha + qp.
- R7: In post-loop mode, when not skipped, the block counts the seven adjacent pixel pairs whose absolute difference is at most 2. A count of at least 6 gives STRONG; otherwise the result is WEAK.
- R8: `tc` is bs + (qp >> 2) for an in-loop WEAK result, qp >> 1 for a post-loop WEAK result, and 0 for SKIP or STRONG.
- R9: In post-loop mode the boundary strength input has no effect on the result.
- R10: While `in_valid` is low, `mode` and `tc` hold their previous values.
- R11: After reset, `out_valid`, `mode` and `tc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry an edge segment to classify |
| post_mode | input | 1 | 0 = in-loop rule set, 1 = post-loop rule set |
| bs | input | 3 | Boundary strength code (in-loop only) |
| qp | input | 5 | Quantizer parameter, 0 to 31 |
| pix | input | 64 | Eight 8-bit pixels, p3 in the low byte through q3 in the high byte |
| alpha | input | 8 | Step threshold across the edge |
| beta | input | 8 | Gradient threshold on each side |
| out_valid | output | 1 | Registered decision is valid |
| mode | output | 2 | 0 SKIP, 1 WEAK, 2 STRONG |
| tc | output | 5 | Clipping bound for the weak filter |

## Verification
The bench drives each threshold exactly at equality: a step equal to alpha, a gradient equal to beta, and in post-loop a step equal to alpha+qp. A design that used non-strict comparisons would filter these edges instead of skipping them. It drives pixel pairs that differ by exactly 2 and by 3, and flat counts of exactly 6 and 5. An off-by-one in the flatness test or the count threshold would then swap STRONG and WEAK. It also applies strength codes above 4, nonzero strength in post-loop mode and idle cycles between decisions. These catch a design that decodes the strength as equality with 4, lets the strength leak into the post-loop rules, or updates the outputs without `in_valid`.

// File: rtl/deblock_mode_decide.sv
module deblock_mode_decide #(
  parameter int PW         = 8,
  parameter int QW         = 5,
  parameter int BSW        = 3,
  parameter int TW         = 5,
  parameter int FLAT_DIFF  = 2,
  parameter int STRONG_CNT = 6,
  parameter int BS_STRONG  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            post_mode,
  input  logic [BSW-1:0]  bs,
  input  logic [QW-1:0]   qp,
  input  logic [8*PW-1:0] pix,
  input  logic [PW-1:0]   alpha,
  input  logic [PW-1:0]   beta,
  output logic            out_valid,
  output logic [1:0]      mode,
  output logic [TW-1:0]   tc
);
  localparam logic [1:0] M_SKIP = 2'd0, M_WEAK = 2'd1, M_STRONG = 2'd2;

  function automatic logic [PW-1:0] absd(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  logic [PW-1:0] px [8];
  logic [6:0]    flat;

  for (genvar i = 0; i < 8; i++) begin : g_px
    assign px[i] = pix[i*PW +: PW];
  end
  for (genvar j = 0; j < 7; j++) begin : g_flat
    assign flat[j] = absd(px[j], px[j+1]) <= PW'(FLAT_DIFF);
  end

  logic [PW:0] edge_thr;
  logic        edge_ok, side_ok, is_flat;
  logic [3:0]  flat_cnt;

  assign edge_thr = post_mode ? ({1'b0, alpha} + (PW+1)'(qp)) : {1'b0, alpha};
  assign edge_ok  = {1'b0, absd(px[3], px[4])} < edge_thr;
  assign side_ok  = (absd(px[2], px[3]) < beta) && (absd(px[5], px[4]) < beta);
  assign flat_cnt = 4'($countones(flat));
  assign is_flat  = flat_cnt >= 4'(STRONG_CNT);

  logic [1:0]    mode_d;
  logic [TW-1:0] tc_d;

  always_comb begin
    mode_d = M_SKIP;
    tc_d   = '0;
    if (post_mode) begin
      if (edge_ok) begin
        mode_d = is_flat ? M_STRONG : M_WEAK;
        if (!is_flat) tc_d = TW'(qp >> 1);
      end
    end else if (bs != '0 && edge_ok && side_ok) begin
      if (bs >= BSW'(BS_STRONG)) begin
        mode_d = M_STRONG;
      end else begin
        mode_d = M_WEAK;
        tc_d   = TW'(bs) + TW'(qp >> 2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mode      <= M_SKIP;
      tc        <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mode <= mode_d;
        tc   <= tc_d;
      end
    end
  end

  // R1
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  // R2
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
  // R3
  a_r3_bs0_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !post_mode && bs == '0) |=> mode == M_SKIP);
  // R8
  a_r8_tc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode != M_WEAK) |-> tc == '0);
  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(mode) && $stable(tc)));
endmodule

// File: tb/tb_deblock_mode_decide.sv
module tb_deblock_mode_decide;
  logic        clk = 0, rst_n = 0, in_valid = 0, post_mode = 0;
  logic [2:0]  bs = 0;
  logic [4:0]  qp = 0;
  logic [63:0] pix = 0;
  logic [7:0]  alpha = 0, beta = 0;
  logic        out_valid;
  logic [1:0]  mode;
  logic [4:0]  tc;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  deblock_mode_decide dut (.clk, .rst_n, .in_valid, .post_mode, .bs, .qp, .pix,
                           .alpha, .beta, .out_valid, .mode, .tc);

  localparam logic [63:0] FLAT  = 64'h64646464_64646464;
  localparam logic [63:0] STEP  = 64'h6E6E6E6E_64646464;
  localparam logic [63:0] PGRAD = 64'h64646464_64686464;
  localparam logic [63:0] QGRAD = 64'h64646064_64646464;
  localparam logic [63:0] CNT5  = 64'h6A6A6764_64646464;
  localparam logic [63:0] D2    = 64'h6A686664_64646464;
  localparam logic [63:0] D3    = 64'h6D6A6764_64646464;

  // {post, bs, qp, alpha, beta, pix, exp_mode, exp_tc}
  localparam int NV = 16;
  localparam logic [95:0] VEC [NV] = '{
    {1'b0, 3'd0, 5'd20, 8'd10, 8'd4, FLAT,  2'd0, 5'd0},  // R3
    {1'b0, 3'd2, 5'd20, 8'd10, 8'd4, FLAT,  2'd1, 5'd7},  // R5 R8
    {1'b0, 3'd4, 5'd20, 8'd10, 8'd4, FLAT,  2'd2, 5'd0},  // R5
    {1'b0, 3'd7, 5'd3,  8'd10, 8'd4, FLAT,  2'd2, 5'd0},  // R5
    {1'b0, 3'd3, 5'd0,  8'd10, 8'd4, STEP,  2'd0, 5'd0},  // R4 alpha equal
    {1'b0, 3'd3, 5'd0,  8'd11, 8'd4, STEP,  2'd1, 5'd3},  // R4 R8
    {1'b0, 3'd1, 5'd8,  8'd10, 8'd4, PGRAD, 2'd0, 5'd0},  // R4 p beta equal
    {1'b0, 3'd1, 5'd8,  8'd10, 8'd5, PGRAD, 2'd1, 5'd3},  // R4 R8
    {1'b0, 3'd4, 5'd8,  8'd10, 8'd4, QGRAD, 2'd0, 5'd0},  // R4 q beta equal
    {1'b1, 3'd0, 5'd10, 8'd0,  8'd0, FLAT,  2'd2, 5'd0},  // R7
    {1'b1, 3'd4, 5'd10, 8'd0,  8'd0, STEP,  2'd0, 5'd0},  // R6 equal
    {1'b1, 3'd0, 5'd11, 8'd0,  8'd0, STEP,  2'd2, 5'd0},  // R6 R7 count 6
    {1'b1, 3'd4, 5'd9,  8'd5,  8'd0, CNT5,  2'd1, 5'd4},  // R7 R9 count 5
    {1'b1, 3'd0, 5'd9,  8'd5,  8'd0, CNT5,  2'd1, 5'd4},  // R9
    {1'b1, 3'd5, 5'd4,  8'd1,  8'd0, D2,    2'd2, 5'd0},  // R7 diff 2 flat
    {1'b1, 3'd5, 5'd4,  8'd1,  8'd0, D3,    2'd1, 5'd2}   // R7 R8 diff 3
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 out_valid", out_valid, 0);
    chk("R11 mode", mode, 0);
    chk("R11 tc", tc, 0);
    rst_n = 1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {post_mode, bs, qp, alpha, beta, pix} = VEC[k][95:7];
      in_valid = 1;
      @(negedge clk);
      chk("R1 valid", out_valid, 1);
      chk($sformatf("R2 mode vec%0d", k), mode, VEC[k][6:5]);
      chk($sformatf("R8 tc vec%0d", k), tc, VEC[k][4:0]);
    end
    // R10: idle inputs change, outputs hold (last result WEAK tc=2)
    in_valid = 0; post_mode = 0; bs = 3'd4; pix = FLAT; alpha = 8'd10; beta = 8'd4;
    @(negedge clk);
    chk("R1 valid low", out_valid, 0);
    repeat (2) @(negedge clk);
    chk("R10 mode held", mode, 1);
    chk("R10 tc held", tc, 2);
    // R1 back-to-back: two decisions in consecutive cycles
    in_valid = 1; bs = 3'd0;
    @(negedge clk);
    chk("R3 b2b first", mode, 0);
    bs = 3'd4;
    @(negedge clk);
    chk("R5 b2b second", mode, 2);
    in_valid = 0;
    // R11 reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R11 reset mode", mode, 0);
    chk("R11 reset valid", out_valid, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule